// File: doc/BRIEF.md
# Bridge Configuration Register File

This block is the byte-wide configuration space of a PCI-to-ISA bridge function. A simple port with a write strobe, a read strobe, an 8-bit offset and byte data reaches a 256-byte space. Identification bytes are constants. A defined set of offsets holds writable bytes with reset defaults. The remaining offsets read as zero and ignore writes.

Writes to some offsets have side effects. A status byte clears its bits when software writes ones to them, under a mask. A write to the power-management control byte can raise a one-cycle interrupt request on one of two lines. A write to the SMM control byte can raise a one-cycle SMI request, but only while the processor is outside SMM. A small state machine holds the ISA clock divisor selected by a mode byte and keeps the previous choice when software writes the reserved code. A ratio bit selects the host-to-PCI clock relationship. Two bytes carry four interrupt-routing nibbles, which leave the block as control outputs.

The divisor state machine has three states: `DIV_BY3` (the reset state), `DIV_BY4` and `DIV_BY2`. Its transitions happen only on a write to offset 0x56. Code 00 goes to `DIV_BY3`, 01 goes to `DIV_BY4` and 10 goes to `DIV_BY2`, each from any state. Code 11 is a self-loop that keeps the current state.

Top module: `bridge_cfg_regs`

## Requirements
- R1: While `rst` is high at a rising edge, every writable byte returns to its default. The defaults are 0x0F at 0x04, 0x01/0x06/0x08 at 0x40/0x41/0x42, 0x9A at 0x43, 0xBC at 0x44, 0x40 at 0x47, 0x01/0x03 at 0x50/0x51 and 0x20 at 0xA8, and 0x00 for every other writable byte. The status byte at 0x07 resets to 0x02.
- R2: The identification bytes are read-only constants: 0x00=0x60, 0x01=0x10, 0x02/0x03 = DEV_ID low byte then high byte (0x86, 0x88 by default), 0x08=0x0E, 0x09=0x00, 0x0A=0x01, 0x0B=0x06. Writes to them leave their read value unchanged.
- R3: The writable offsets are 0x04, 0x05, 0x0C, 0x0D, 0x40–0x47, 0x50–0x57, 0x70–0x76, 0x80, 0x81, 0x90–0x92 and 0xA0–0xA8. A write to one of them stores the whole byte. Every other offset except 0x07 ignores writes, and offsets that are neither identification nor writable read 0x00.
- R4: A write to 0x07 clears each bit that is 1 in both the written data and the mask 0xF9, and leaves the other bits alone. Each cycle, each bit of `status_evt` sets the matching status bit. When a set and a clear hit the same bit in one cycle, the set wins.
- R5: `smi_req` is high for exactly the one cycle after an edge that accepts a write to 0xA3 with data bits 7 and 6 both 1 while `in_smm` is 0. It stays low at all other times.
- R6: A write to 0x46 with data bit 6 set pulses `irq15_req` for one cycle if data bit 7 is 1, or pulses `irq10_req` for one cycle if bit 7 is 0. With bit 6 clear, neither line pulses.
- R7: `isa_div` gives the ISA clock divisor: 3 after reset. After a write to 0x56 it becomes 3, 4 or 2 for data bits 1:0 = 00, 01 or 10, and it holds its previous value for code 11.
- R8: `pci_full_rate` equals bit 0 of offset 0xA4: 1 means host and PCI clocks run 1:1, and 0 means the PCI clock runs at half the host rate. It is 0 after reset.
- R9: `route_a`/`route_b` are bits 3:0 and 7:4 of offset 0x43, and `route_c`/`route_d` are bits 3:0 and 7:4 of offset 0x44. Each nibble is an interrupt line number, and 0 means not routed.
- R10: `rd_data` shows the byte at `addr` in the same cycle that `rd_en` is high, and shows 0x00 while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, accepted at the rising edge |
| rd_en | input | 1 | Read strobe, combinational read |
| addr | input | 8 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| in_smm | input | 1 | High while the processor is in SMM |
| status_evt | input | 8 | Per-bit set requests for the status byte |
| smi_req | output | 1 | One-cycle software SMI request |
| irq10_req | output | 1 | One-cycle interrupt request on line 10 |
| irq15_req | output | 1 | One-cycle interrupt request on line 15 |
| isa_div | output | 3 | ISA clock divisor (2, 3 or 4) |
| pci_full_rate | output | 1 | 1: host-to-PCI clocks 1:1, 0: half rate |
| route_a | output | 4 | Interrupt routing nibble A |
| route_b | output | 4 | Interrupt routing nibble B |
| route_c | output | 4 | Interrupt routing nibble C |
| route_d | output | 4 | Interrupt routing nibble D |

## Verification
The assertions assume that `addr`, `wr_data`, `wr_en` and `in_smm` are stable at each rising edge and that `in_smm` is a level, not a pulse, so a write and its SMM state are seen in the same sample. They also assume that no interrupt or SMI write is issued before the first cycle after reset ends. The bench drives every input on the falling edge, holds `rst` for several cycles before any access, and issues single-cycle writes and reads. It steps `in_smm` only between writes, so each side-effect write can be traced to a single sampled input set.

// File: rtl/bridge_cfg_pkg.sv
package bridge_cfg_pkg;

    typedef enum logic [1:0] {
        DIV_BY3 = 2'd0,
        DIV_BY4 = 2'd1,
        DIV_BY2 = 2'd2
    } isa_div_e;

    localparam int OFS_STATUS  = 8'h07;
    localparam int OFS_ROUTE_L = 8'h43;
    localparam int OFS_ROUTE_H = 8'h44;
    localparam int OFS_PMU     = 8'h46;
    localparam int OFS_ISA_CLK = 8'h56;
    localparam int OFS_SMM     = 8'hA3;
    localparam int OFS_RATIO   = 8'hA4;

    localparam logic [7:0] STATUS_W1C_MASK = 8'hF9;
    localparam logic [7:0] STATUS_RESET    = 8'h02;

    function automatic bit is_writable(int a);
        return (a == 8'h04) || (a == 8'h05) || (a == 8'h0C) || (a == 8'h0D)
            || (a >= 8'h40 && a <= 8'h47) || (a >= 8'h50 && a <= 8'h57)
            || (a >= 8'h70 && a <= 8'h76) || (a == 8'h80) || (a == 8'h81)
            || (a >= 8'h90 && a <= 8'h92) || (a >= 8'hA0 && a <= 8'hA8);
    endfunction

    function automatic logic [7:0] reset_byte(int a);
        case (a)
            8'h04:   return 8'h0F;
            8'h40:   return 8'h01;
            8'h41:   return 8'h06;
            8'h42:   return 8'h08;
            8'h43:   return 8'h9A;
            8'h44:   return 8'hBC;
            8'h47:   return 8'h40;
            8'h50:   return 8'h01;
            8'h51:   return 8'h03;
            8'hA8:   return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] fixed_byte(int a, logic [15:0] dev_id);
        case (a)
            8'h00:   return 8'h60;
            8'h01:   return 8'h10;
            8'h02:   return dev_id[7:0];
            8'h03:   return dev_id[15:8];
            8'h08:   return 8'h0E;
            8'h0A:   return 8'h01;
            8'h0B:   return 8'h06;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_byte_store.sv
module cfg_byte_store
    import bridge_cfg_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter logic [15:0] DEV_ID = 16'h8886,
    localparam int         NREG   = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        status_evt,
    output logic [7:0]        cfg_view [NREG]
);

    for (genvar i = 0; i < NREG; i++) begin : g_byte
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(i);
        if (i == OFS_STATUS) begin : g_status
            logic [7:0] stat_q;
            logic [7:0] clr;
            always_comb clr = (wr_en && addr == OFS) ? (wr_data & STATUS_W1C_MASK) : 8'h00;
            always_ff @(posedge clk) begin
                if (rst) stat_q <= STATUS_RESET;
                else     stat_q <= (stat_q & ~clr) | status_evt;
            end
            assign cfg_view[i] = stat_q;
        end else if (is_writable(i)) begin : g_rw
            logic [7:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst)                      byte_q <= reset_byte(i);
                else if (wr_en && addr == OFS) byte_q <= wr_data;
            end
            assign cfg_view[i] = byte_q;
        end else begin : g_ro
            assign cfg_view[i] = fixed_byte(i, DEV_ID);
        end
    end

endmodule

// File: rtl/cfg_isa_div_fsm.sv
module cfg_isa_div_fsm
    import bridge_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_wr,
    input  logic [1:0] sel_code,
    output logic [2:0] isa_div
);

    isa_div_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (sel_wr) begin
            unique case (sel_code)
                2'b00: state_d = DIV_BY3;
                2'b01: state_d = DIV_BY4;
                2'b10: state_d = DIV_BY2;
                2'b11: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DIV_BY3;
        else     state_q <= state_d;
    end

    always_comb begin
        case (state_q)
            DIV_BY4: isa_div = 3'd4;
            DIV_BY2: isa_div = 3'd2;
            default: isa_div = 3'd3;
        endcase
    end

endmodule

// File: rtl/cfg_pulse_gen.sv
module cfg_pulse_gen (
    input  logic clk,
    input  logic rst,
    input  logic smm_wr,
    input  logic smm_unlock,
    input  logic smm_trigger,
    input  logic in_smm,
    input  logic pmu_wr,
    input  logic pmu_request,
    input  logic pmu_line_hi,
    output logic smi_req,
    output logic irq10_req,
    output logic irq15_req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            smi_req   <= 1'b0;
            irq10_req <= 1'b0;
            irq15_req <= 1'b0;
        end else begin
            smi_req   <= smm_wr && smm_unlock && smm_trigger && !in_smm;
            irq10_req <= pmu_wr && pmu_request && !pmu_line_hi;
            irq15_req <= pmu_wr && pmu_request && pmu_line_hi;
        end
    end

endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
    import bridge_cfg_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter logic [15:0] DEV_ID = 16'h8886
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              in_smm,
    input  logic [7:0]        status_evt,
    output logic              smi_req,
    output logic              irq10_req,
    output logic              irq15_req,
    output logic [2:0]        isa_div,
    output logic              pci_full_rate,
    output logic [3:0]        route_a,
    output logic [3:0]        route_b,
    output logic [3:0]        route_c,
    output logic [3:0]        route_d
);

    localparam int NREG = 1 << ADDR_W;

    logic [7:0] cfg_view [NREG];

    cfg_byte_store #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) store_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .status_evt(status_evt), .cfg_view(cfg_view)
    );

    cfg_isa_div_fsm div_i (
        .clk(clk), .rst(rst),
        .sel_wr(wr_en && addr == ADDR_W'(OFS_ISA_CLK)),
        .sel_code(wr_data[1:0]),
        .isa_div(isa_div)
    );

    cfg_pulse_gen pulse_i (
        .clk(clk), .rst(rst),
        .smm_wr(wr_en && addr == ADDR_W'(OFS_SMM)),
        .smm_unlock(wr_data[7]), .smm_trigger(wr_data[6]), .in_smm(in_smm),
        .pmu_wr(wr_en && addr == ADDR_W'(OFS_PMU)),
        .pmu_request(wr_data[6]), .pmu_line_hi(wr_data[7]),
        .smi_req(smi_req), .irq10_req(irq10_req), .irq15_req(irq15_req)
    );

    always_comb rd_data = rd_en ? cfg_view[addr] : 8'h00;

    assign pci_full_rate = cfg_view[OFS_RATIO][0];
    assign route_a       = cfg_view[OFS_ROUTE_L][3:0];
    assign route_b       = cfg_view[OFS_ROUTE_L][7:4];
    assign route_c       = cfg_view[OFS_ROUTE_H][3:0];
    assign route_d       = cfg_view[OFS_ROUTE_H][7:4];

endmodule

// File: rtl/bridge_cfg_chk.sv
module bridge_cfg_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] addr,
    input logic [7:0] wr_data,
    input logic       in_smm,
    input logic       smi_req,
    input logic       irq10_req,
    input logic       irq15_req,
    input logic [2:0] isa_div,
    input logic       pci_full_rate
);

    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= !rst;

    logic smi_cause, irq15_cause, div_wr, ratio_wr;
    assign smi_cause   = wr_en && addr == 8'hA3 && wr_data[7:6] == 2'b11 && !in_smm;
    assign irq15_cause = wr_en && addr == 8'h46 && wr_data[7:6] == 2'b11;
    assign div_wr      = wr_en && addr == 8'h56;
    assign ratio_wr    = wr_en && addr == 8'hA4;

    // R5
    a_r5_smi_cause: assert property (@(posedge clk) disable iff (rst || !armed)
        smi_req |-> $past(smi_cause));
    a_r5_smi_fire: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(smi_cause) |-> smi_req);
    // R6
    a_r6_one_line: assert property (@(posedge clk) disable iff (rst)
        !(irq10_req && irq15_req));
    a_r6_irq15_cause: assert property (@(posedge clk) disable iff (rst || !armed)
        irq15_req |-> $past(irq15_cause));
    // R7
    a_r7_div_legal: assert property (@(posedge clk) disable iff (rst)
        isa_div == 3'd2 || isa_div == 3'd3 || isa_div == 3'd4);
    a_r7_div_hold: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(div_wr) |-> $stable(isa_div));
    // R8
    a_r8_ratio_hold: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(ratio_wr) |-> $stable(pci_full_rate));

endmodule

bind bridge_cfg_regs bridge_cfg_chk chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .in_smm(in_smm), .smi_req(smi_req), .irq10_req(irq10_req),
    .irq15_req(irq15_req), .isa_div(isa_div), .pci_full_rate(pci_full_rate)
);

// File: tb/bridge_cfg_regs_tb_top.sv
module bridge_cfg_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, in_smm = 1'b0;
    logic [7:0] addr = 8'h00, wr_data = 8'h00, status_evt = 8'h00;
    logic [7:0] rd_data;
    logic       smi_req, irq10_req, irq15_req, pci_full_rate;
    logic [2:0] isa_div;
    logic [3:0] route_a, route_b, route_c, route_d;

    int total = 0, bad = 0;

    always #5 clk = ~clk;

    bridge_cfg_regs dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .in_smm(in_smm),
        .status_evt(status_evt), .smi_req(smi_req), .irq10_req(irq10_req),
        .irq15_req(irq15_req), .isa_div(isa_div), .pci_full_rate(pci_full_rate),
        .route_a(route_a), .route_b(route_b), .route_c(route_c), .route_d(route_d)
    );

    // behavioural reference model
    byte unsigned m_mem [256];
    int           m_div;
    bit           m_smi, m_i10, m_i15;

    function automatic bit rw_ofs(int a);
        return a inside {8'h04, 8'h05, 8'h0C, 8'h0D, [8'h40:8'h47], [8'h50:8'h57],
                         [8'h70:8'h76], 8'h80, 8'h81, [8'h90:8'h92], [8'hA0:8'hA8]};
    endfunction

    task automatic model_reset();
        foreach (m_mem[i]) m_mem[i] = 0;
        m_mem[8'h00] = 8'h60; m_mem[8'h01] = 8'h10; m_mem[8'h02] = 8'h86; m_mem[8'h03] = 8'h88;
        m_mem[8'h08] = 8'h0E; m_mem[8'h0A] = 8'h01; m_mem[8'h0B] = 8'h06;
        m_mem[8'h04] = 8'h0F; m_mem[8'h07] = 8'h02;
        m_mem[8'h40] = 8'h01; m_mem[8'h41] = 8'h06; m_mem[8'h42] = 8'h08;
        m_mem[8'h43] = 8'h9A; m_mem[8'h44] = 8'hBC; m_mem[8'h47] = 8'h40;
        m_mem[8'h50] = 8'h01; m_mem[8'h51] = 8'h03; m_mem[8'hA8] = 8'h20;
        m_div = 3; m_smi = 0; m_i10 = 0; m_i15 = 0;
    endtask

    task automatic check(bit ok, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // one clock: predict, advance, compare every output at the falling edge
    task automatic step();
        if (rst) model_reset();
        else begin
            m_smi = wr_en && addr == 8'hA3 && wr_data[7:6] == 2'b11 && !in_smm;
            m_i10 = wr_en && addr == 8'h46 && wr_data[6] && !wr_data[7];
            m_i15 = wr_en && addr == 8'h46 && wr_data[6] && wr_data[7];
            if (wr_en && addr == 8'h56 && wr_data[1:0] != 2'b11)
                m_div = (wr_data[1:0] == 2'b00) ? 3 : (wr_data[1:0] == 2'b01) ? 4 : 2;
            if (wr_en && addr == 8'h07) m_mem[7] = m_mem[7] & ~(wr_data & 8'hF9);
            else if (wr_en && rw_ofs(addr)) m_mem[addr] = wr_data;
            m_mem[7] = m_mem[7] | status_evt;
        end
        @(posedge clk);
        @(negedge clk);
        check(smi_req == m_smi, "R5 smi_req", smi_req, m_smi);
        check(irq10_req == m_i10 && irq15_req == m_i15, "R6 irq10/irq15",
              {irq10_req, irq15_req}, {m_i10, m_i15});
        check(isa_div == m_div, "R7 isa_div", isa_div, m_div);
        check(pci_full_rate == m_mem[8'hA4][0], "R8 pci_full_rate", pci_full_rate, m_mem[8'hA4][0]);
        check({route_d, route_c, route_b, route_a} == {m_mem[8'h44], m_mem[8'h43]},
              "R9 routes", {route_d, route_c, route_b, route_a}, {m_mem[8'h44], m_mem[8'h43]});
    endtask

    task automatic wr(byte unsigned a, byte unsigned d);
        wr_en = 1; addr = a; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic rd_chk(byte unsigned a, string tag);
        rd_en = 1; addr = a;
        #1;
        check(rd_data == m_mem[a], $sformatf("%s read @%02h", tag, a), rd_data, m_mem[a]);
        rd_en = 0;
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        repeat (3) step();
        rst = 0;
        step();

        // R1 R2 R3: every offset after reset
        for (int a = 0; a < 256; a++) rd_chk(8'(a), "R1/R2");

        // R10: idle read port
        addr = 8'h43; #1;
        check(rd_data == 8'h00, "R10 idle read", rd_data, 0);

        // R3: writable and ignored offsets
        wr(8'h45, 8'h5A); rd_chk(8'h45, "R3");
        wr(8'h91, 8'hC3); rd_chk(8'h91, "R3");
        wr(8'h30, 8'hFF); rd_chk(8'h30, "R3");
        wr(8'hFF, 8'h77); rd_chk(8'hFF, "R3");
        wr(8'hA9, 8'h11); rd_chk(8'hA9, "R3");
        // R2: identification bytes ignore writes
        wr(8'h00, 8'h00); rd_chk(8'h00, "R2");
        wr(8'h03, 8'h12); rd_chk(8'h03, "R2");
        wr(8'h0B, 8'hFF); rd_chk(8'h0B, "R2");

        // R4: status sticky set and masked clear
        status_evt = 8'hFF; step(); status_evt = 8'h00;
        rd_chk(8'h07, "R4");
        wr(8'h07, 8'hFF); rd_chk(8'h07, "R4");
        wr(8'h07, 8'h00); rd_chk(8'h07, "R4");
        status_evt = 8'h81; wr(8'h07, 8'h80); status_evt = 8'h00;
        rd_chk(8'h07, "R4");
        wr(8'h07, 8'h81); rd_chk(8'h07, "R4");

        // R5: SMI request conditions
        wr(8'hA3, 8'hC0); step();
        in_smm = 1; wr(8'hA3, 8'hC0); in_smm = 0;
        wr(8'hA3, 8'h80); wr(8'hA3, 8'h40); wr(8'hA3, 8'hFF);
        wr(8'hA2, 8'hC0); rd_chk(8'hA3, "R5");

        // R6: interrupt line selection
        wr(8'h46, 8'h40); wr(8'h46, 8'hC0); wr(8'h46, 8'h80); wr(8'h46, 8'h00);
        step();

        // R7: divisor state machine including reserved code
        wr(8'h56, 8'h01); wr(8'h56, 8'h03); wr(8'h56, 8'h02); wr(8'h56, 8'h03);
        wr(8'h56, 8'h00); wr(8'h57, 8'h01); wr(8'h56, 8'hFD);
        rd_chk(8'h56, "R7");

        // R8 R9: ratio and routing
        wr(8'hA4, 8'h01); wr(8'hA4, 8'hFE); wr(8'hA4, 8'h03);
        wr(8'h43, 8'h3E); wr(8'h44, 8'h05); wr(8'h44, 8'hF0);

        // back-to-back side effects
        wr(8'h46, 8'h40); wr(8'hA3, 8'hC0); wr(8'h56, 8'h02);

        // R1: reset mid-run restores defaults
        rst = 1; step(); step(); rst = 0; step();
        rd_chk(8'h43, "R1"); rd_chk(8'h44, "R1"); rd_chk(8'h07, "R1");
        rd_chk(8'hA4, "R1"); rd_chk(8'h45, "R1"); rd_chk(8'h56, "R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule